// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit adder for datapaths where a rippled carry is too slow. It takes two operands and a carry-in and returns the 16-bit sum, the carry-out and a two's-complement overflow flag, all settled within the same cycle as the inputs.

Internally the operands are cut into four 4-bit slices. Every slice derives a generate bit (both operand bits set) and a propagate bit (either operand bit set) for each position. It forms all of its own carries directly from those signals and the slice carry-in, and it summarises itself as one group generate and one group propagate. A second lookahead level takes the four slice summaries and the carry-in. From them it forms the carries into bits 4, 8 and 12 and the final carry-out in parallel. Slice width is kept at four because the widest carry term then needs a five-input gate. The second level also produces a block-wide generate and propagate pair, so a wider adder could treat this block as one group of a third lookahead level.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals `(op_a + op_b + carry_in) mod 2^16` for every input combination.
- R2: `carry_o` equals bit 16 of the unsigned 17-bit result of `op_a + op_b + carry_in`.
- R3: `ovf_o` is 1 exactly when `op_a[15]` equals `op_b[15]` and `sum_o[15]` differs from them, i.e. the two's-complement result does not fit in 16 bits.
- R4: With `carry_in` = 1 the result is one greater than with `carry_in` = 0. Example: 0xFFFF + 0x0000 + 1 gives sum 0x0000 and carry-out 1.
- R5: Carries cross slice boundaries correctly. A carry born in bit 3, 7 or 11 reaches bit 4, 8 or 12 respectively, and one born in bit 15 reaches `carry_o`. Examples: 0x000F + 0x0001 = 0x0010, 0x00FF + 0x0001 = 0x0100, 0x0FFF + 0x0001 = 0x1000, 0x8000 + 0x8000 gives 0x0000 with carry-out 1.
- R6: `blk_prop_o` is 1 exactly when every bit position has `op_a[i] | op_b[i]` = 1.
- R7: `blk_gen_o` is 1 exactly when `op_a + op_b` with no carry-in produces a carry out of bit 15. It does not depend on `carry_in`.
- R8: Zero plus zero with no carry-in gives sum 0, carry-out 0, overflow 0 and both block flags 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum modulo 2^16 |
| carry_o | output | 1 | Carry out of bit 15 |
| ovf_o | output | 1 | Signed overflow |
| blk_gen_o | output | 1 | Block-wide generate for a further lookahead level |
| blk_prop_o | output | 1 | Block-wide propagate for a further lookahead level |

## Verification
The assertions sit in combinational processes. They assume all inputs are held steady and fully known while they are evaluated, with no X or Z bits and no change during the evaluation. The bench meets this by changing operands only on the falling clock edge and sampling two nanoseconds later, once the whole lookahead network has settled. Operands are always driven as complete 16-bit values, whether they are directed corner cases or values from the random generator.

// File: rtl/cla16_pkg.sv
package cla16_pkg;

  // Summary of a group of bit positions for the next lookahead level.
  typedef struct packed {
    logic gen;
    logic prop;
  } grp_sig_t;

  // A position creates a carry on its own.
  function automatic logic bit_gen(input logic x, input logic y);
    return x & y;
  endfunction

  // A position passes an incoming carry on.
  function automatic logic bit_prop(input logic x, input logic y);
    return x | y;
  endfunction

  function automatic logic sum_bit(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

endpackage

// File: rtl/cla_carry_net.sv
module cla_carry_net
  import cla16_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin,
  output logic [N:0]   carry_o,
  output grp_sig_t     grp_o
);

  // Flat two-level form of the carry into position idx: OR of every
  // generate term passed through all higher propagates, plus cin
  // passed through every propagate below idx.
  function automatic logic flat_carry(input logic [N-1:0] g,
                                      input logic [N-1:0] p,
                                      input logic         c0,
                                      input int           idx);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < idx; j++) begin
      term = g[j];
      for (int k = j + 1; k < idx; k++) term = term & p[k];
      acc = acc | term;
    end
    term = c0;
    for (int k = 0; k < idx; k++) term = term & p[k];
    return acc | term;
  endfunction

  function automatic logic all_prop(input logic [N-1:0] p);
    logic acc;
    acc = 1'b1;
    for (int k = 0; k < N; k++) acc = acc & p[k];
    return acc;
  endfunction

  for (genvar i = 0; i <= N; i++) begin : g_carry
    assign carry_o[i] = flat_carry(gen_i, prop_i, cin, i);
  end

  assign grp_o.gen  = flat_carry(gen_i, prop_i, 1'b0, N);
  assign grp_o.prop = all_prop(prop_i);

  // The parallel carries must agree with the step-by-step recurrence.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      AST_RIPPLE_AGREES: assert (carry_o[i+1] == (gen_i[i] | (prop_i[i] & carry_o[i])))
        else $error("carry %0d disagrees with recurrence", i + 1); // R5
    end
    AST_GROUP_FORM: assert (carry_o[N] == (grp_o.gen | (grp_o.prop & cin)))
      else $error("group summary inconsistent with group carry-out"); // R7
  end

endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla16_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin,
  output logic [W-1:0] sum_o,
  output grp_sig_t     grp_o,
  output logic         msb_carry_o,
  output logic         cout_o
);

  logic [W-1:0] gen_w;
  logic [W-1:0] prop_w;
  logic [W:0]   carry_w;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_w[i]  = bit_gen(x_i[i], y_i[i]);
    assign prop_w[i] = bit_prop(x_i[i], y_i[i]);
    assign sum_o[i]  = sum_bit(x_i[i], y_i[i], carry_w[i]);
  end

  cla_carry_net #(.N(W)) u_net (
    .gen_i  (gen_w),
    .prop_i (prop_w),
    .cin    (cin),
    .carry_o(carry_w),
    .grp_o  (grp_o)
  );

  assign msb_carry_o = carry_w[W-1];
  assign cout_o      = carry_w[W];

  always_comb begin
    AST_SLICE_ADD: assert ({cout_o, sum_o} == ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin}))
      else $error("slice sum mismatch"); // R1
  end

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla16_pkg::*;
#(
  parameter int SLICE_W   = 4,
  parameter int SLICE_CNT = 4
) (
  input  logic [SLICE_W*SLICE_CNT-1:0] op_a,
  input  logic [SLICE_W*SLICE_CNT-1:0] op_b,
  input  logic                         carry_in,
  output logic [SLICE_W*SLICE_CNT-1:0] sum_o,
  output logic                         carry_o,
  output logic                         ovf_o,
  output logic                         blk_gen_o,
  output logic                         blk_prop_o
);

  localparam int WIDTH = SLICE_W * SLICE_CNT;
  localparam int MSB   = WIDTH - 1;

  grp_sig_t [SLICE_CNT-1:0] slc_grp;
  logic     [SLICE_CNT-1:0] slc_gen;
  logic     [SLICE_CNT-1:0] slc_prop;
  logic     [SLICE_CNT-1:0] slc_msb_c;
  logic     [SLICE_CNT-1:0] slc_cout;
  logic     [SLICE_CNT:0]   la_carry;
  grp_sig_t                 blk_grp;

  for (genvar s = 0; s < SLICE_CNT; s++) begin : g_slice
    cla_slice #(.W(SLICE_W)) u_slice (
      .x_i        (op_a[s*SLICE_W +: SLICE_W]),
      .y_i        (op_b[s*SLICE_W +: SLICE_W]),
      .cin        (la_carry[s]),
      .sum_o      (sum_o[s*SLICE_W +: SLICE_W]),
      .grp_o      (slc_grp[s]),
      .msb_carry_o(slc_msb_c[s]),
      .cout_o     (slc_cout[s])
    );
    assign slc_gen[s]  = slc_grp[s].gen;
    assign slc_prop[s] = slc_grp[s].prop;
  end

  // Second lookahead level over the slice summaries.
  cla_carry_net #(.N(SLICE_CNT)) u_lookahead (
    .gen_i  (slc_gen),
    .prop_i (slc_prop),
    .cin    (carry_in),
    .carry_o(la_carry),
    .grp_o  (blk_grp)
  );

  assign carry_o    = la_carry[SLICE_CNT];
  assign blk_gen_o  = blk_grp.gen;
  assign blk_prop_o = blk_grp.prop;
  assign ovf_o      = slc_msb_c[SLICE_CNT-1] ^ carry_o;

  always_comb begin
    AST_SUM_MATCH: assert ({carry_o, sum_o} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("sum/carry mismatch"); // R1
    AST_OVERFLOW_RULE: assert (ovf_o == ((op_a[MSB] == op_b[MSB]) && (sum_o[MSB] != op_a[MSB])))
      else $error("overflow flag wrong"); // R3
    AST_ZERO_ADD: assert (!((op_a == '0) && (op_b == '0) && !carry_in) || ((sum_o == '0) && !carry_o && !ovf_o))
      else $error("zero plus zero wrong"); // R8
    AST_BLK_PROP: assert (blk_prop_o == (&(op_a | op_b)))
      else $error("block propagate wrong"); // R6
    for (int s = 0; s < SLICE_CNT; s++) begin
      AST_SLICE_HANDOFF: assert (slc_cout[s] == la_carry[s+1])
        else $error("slice %0d carry-out disagrees with lookahead", s); // R5
      AST_MSB_CARRY: assert (slc_msb_c[s] ==
                             (op_a[s*SLICE_W+SLICE_W-1] ^ op_b[s*SLICE_W+SLICE_W-1] ^ sum_o[s*SLICE_W+SLICE_W-1]))
        else $error("slice %0d carry into top bit wrong", s); // R3
    end
  end

endmodule

// File: tb/cla16_adder_bench.sv
module cla16_adder_bench;

  logic        clk = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum_o;
  logic        carry_o, ovf_o, blk_gen_o, blk_prop_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cla16_adder u_cla16_adder (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_o     (sum_o),
    .carry_o   (carry_o),
    .ovf_o     (ovf_o),
    .blk_gen_o (blk_gen_o),
    .blk_prop_o(blk_prop_o)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%b expected=%b", tag, op_a, op_b, carry_in, act, exp);
    end
  endtask

  task automatic check_word(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", tag, op_a, op_b, carry_in, act, exp);
    end
  endtask

  // Drive on the falling edge, sample after the network settles, and
  // compare every output against independently computed values.
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [16:0] full;
    logic [16:0] nocin;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    #2;
    full  = 17'(a) + 17'(b) + 17'(c);
    nocin = 17'(a) + 17'(b);
    check_word("R1 sum", sum_o, full[15:0]);
    check_bit("R2 carry", carry_o, full[16]);
    check_bit("R3 overflow", ovf_o, (a[15] == b[15]) && (full[15] != a[15]));
    check_bit("R6 block propagate", blk_prop_o, (a | b) == 16'hFFFF);
    check_bit("R7 block generate", blk_gen_o, nocin[16]);
  endtask

  task automatic t_reset_state();
    #2;
    check_word("R8 initial sum", sum_o, 16'h0000);
    check_bit("R8 initial carry", carry_o, 1'b0);
    check_bit("R8 initial overflow", ovf_o, 1'b0);
  endtask

  task automatic t_zero();
    apply(16'h0000, 16'h0000, 1'b0);
    check_bit("R8 zero block gen", blk_gen_o, 1'b0);
    check_bit("R8 zero block prop", blk_prop_o, 1'b0);
  endtask

  task automatic t_carry_in();
    apply(16'hFFFF, 16'h0000, 1'b1);
    check_word("R4 ones plus cin sum", sum_o, 16'h0000);
    check_bit("R4 ones plus cin carry", carry_o, 1'b1);
    apply(16'h0000, 16'h0000, 1'b1);
    check_word("R4 cin only", sum_o, 16'h0001);
    apply(16'h1234, 16'h4321, 1'b1);
    check_word("R4 cin adds one", sum_o, 16'h5556);
  endtask

  task automatic t_boundaries();
    apply(16'h000F, 16'h0001, 1'b0);
    check_word("R5 into bit 4", sum_o, 16'h0010);
    apply(16'h00FF, 16'h0001, 1'b0);
    check_word("R5 into bit 8", sum_o, 16'h0100);
    apply(16'h0FFF, 16'h0001, 1'b0);
    check_word("R5 into bit 12", sum_o, 16'h1000);
    apply(16'hFFFF, 16'h0001, 1'b0);
    check_bit("R5 ones plus one carry", carry_o, 1'b1);
    apply(16'h8000, 16'h8000, 1'b0);
    check_bit("R5 msb carry", carry_o, 1'b1);
  endtask

  task automatic t_overflow();
    apply(16'h7FFF, 16'h0001, 1'b0);
    check_bit("R3 pos overflow", ovf_o, 1'b1);
    apply(16'h8000, 16'h8000, 1'b0);
    check_bit("R3 neg overflow", ovf_o, 1'b1);
    apply(16'hFFFF, 16'h0001, 1'b0);
    check_bit("R3 mixed no overflow", ovf_o, 1'b0);
    apply(16'h7FFF, 16'h0000, 1'b1);
    check_bit("R3 overflow via cin", ovf_o, 1'b1);
  endtask

  task automatic t_block_flags();
    apply(16'hFFFF, 16'h0000, 1'b0);
    check_bit("R6 all propagate", blk_prop_o, 1'b1);
    check_bit("R7 no generate", blk_gen_o, 1'b0);
    apply(16'hFFFF, 16'h0000, 1'b1);
    check_bit("R7 gen ignores cin", blk_gen_o, 1'b0);
    apply(16'hF0FF, 16'h0F00, 1'b0);
    check_bit("R6 split propagate", blk_prop_o, 1'b1);
    apply(16'hFFFE, 16'h0000, 1'b0);
    check_bit("R6 one hole", blk_prop_o, 1'b0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom)); // R1 R2 R3 R6 R7
    end
  endtask

  initial begin
    t_reset_state();
    t_zero();
    t_carry_in();
    t_boundaries();
    t_overflow();
    t_block_flags();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule